// File: doc/BRIEF.md
# Capture Channel Time Base

This block is the up-counting time base that sits beside a capture channel. A capture buffer, outside this block, samples `count` whenever a capture strobe arrives. The counter advances only on ticks of a timer clock. A 3-bit select picks that clock from a set of single-cycle enable strobes, or picks the system clock itself.

A 5-bit source select picks one line of a 32-bit source vector. The block has three modes. With no source and no trigger mode, the counter runs freely and wraps. In sync mode, a high level on the chosen line clears the counter and holds it at zero. In trigger mode, the counter stays at zero until a rising edge on the chosen line, or a software set, raises a run status bit. A software clear drops the status and zeroes the counter, which arms it for the next edge.

Two instances can be chained into one 32-bit timer. The upper half is built with cascade enabled, and its cascade input is fed from the lower half's cascade output.

Top module: `cap_timebase`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `count` is 0, `casc_out` is 0 and `run_stat` is 0.
- R2: Clock select code 7 (binary 111) advances the counter on every system clock cycle.
- R3: Clock select codes 0 to 4 advance the counter only on cycles where `tick_src[code]` is high.
- R4: Clock select codes 5 and 6 never advance the counter.
- R5: The counter wraps from its all-ones value to 0. `casc_out` is high exactly while `count` is all ones.
- R6: In sync mode (`trig_mode`=0 and `src_sel` nonzero), the counter is cleared on a tick when the selected source line is high. It stays at 0 while the line stays high, and counts again from the first tick after the line falls. With no tick, the counter does not clear.
- R7: Source code 0 selects no source. Codes 16 (binary 10000) and 31 (binary 11111) are reserved and read as 0. None of these codes ever clears the counter.
- R8: In trigger mode (`trig_mode`=1), the counter reads 0 while `run_stat` is 0. A rising edge on the selected line sets `run_stat` at that clock edge, and counting starts with the next tick. A line that is held high does not set the status again.
- R9: `sw_set` sets `run_stat`. `sw_clr` clears `run_stat` and takes priority over any set. In trigger mode, `sw_clr` also returns `count` to 0 at the same edge.
- R10: Outside trigger mode, `run_stat` and `sw_clr` have no effect on counting.
- R11: With `casc_en`=1, the counter advances only on ticks where `casc_in` is high. A chained pair therefore behaves as one 32-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | N_TICK (5) | Timer clock enable strobes |
| clk_sel | input | CSEL_W (3) | Timer clock source code |
| src_sel | input | SRC_W (5) | Sync/trigger source code |
| src_vec | input | 2**SRC_W (32) | Sync/trigger source lines |
| trig_mode | input | 1 | 1 selects trigger mode, 0 selects sync/free mode |
| casc_en | input | 1 | Cascade enable |
| casc_in | input | 1 | Cascade input from the lower half |
| sw_set | input | 1 | Software set of run status |
| sw_clr | input | 1 | Software clear of run status |
| count | output | WIDTH (16) | Time base value |
| casc_out | output | 1 | High while count is all ones |
| run_stat | output | 1 | Trigger run status |

## Verification
The bench builds two instances with WIDTH=8 and chains them, so that the pair forms a 16-bit counter. With this width, an all-ones count, the wrap and the carry into the upper half can be reached within a few hundred cycles. The other parameters keep their defaults. This means the reserved clock codes 5 and 6, the reserved source codes 16 and 31, and selection of an individual tick strobe are all exercised at their real encodings.

// File: rtl/cap_timebase_pkg.sv
package cap_timebase_pkg;
  typedef enum logic [1:0] {
    TB_FREE = 2'd0,
    TB_SYNC = 2'd1,
    TB_TRIG = 2'd2
  } tb_mode_e;
endpackage

// File: rtl/cap_tick_mux.sv
module cap_tick_mux #(
  parameter int N_TICK = 5,
  parameter int CSEL_W = 3
) (
  input  logic [N_TICK-1:0] tick_src,
  input  logic [CSEL_W-1:0] clk_sel,
  output logic              tick
);
  localparam int N_CODE = 1 << CSEL_W;

  logic [N_CODE-1:0] code_tick;

  // Low codes map to strobes, the top code to the system clock, the rest stay idle.
  genvar g;
  generate
    for (g = 0; g < N_CODE; g++) begin : g_code
      if (g < N_TICK) begin : g_src
        assign code_tick[g] = tick_src[g];
      end else if (g == N_CODE - 1) begin : g_sys
        assign code_tick[g] = 1'b1;
      end else begin : g_rsv
        assign code_tick[g] = 1'b0;
      end
    end
  endgenerate

  assign tick = code_tick[clk_sel];
endmodule

// File: rtl/cap_src_pick.sv
module cap_src_pick #(
  parameter int          SRC_W     = 5,
  parameter logic [31:0] RSVD_MASK = 32'h8001_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SRC_W-1:0]      src_sel,
  input  logic [(1<<SRC_W)-1:0] src_vec,
  output logic                  src_lvl,
  output logic                  src_rise
);
  localparam int N_SRC = 1 << SRC_W;

  logic [N_SRC-1:0] masked;
  logic             lvl_q;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_mask
      if (g == 0) begin : g_none
        assign masked[g] = 1'b0;
      end else if (g < 32 && RSVD_MASK[g % 32]) begin : g_rsv
        assign masked[g] = 1'b0;
      end else begin : g_live
        assign masked[g] = src_vec[g];
      end
    end
  endgenerate

  assign src_lvl = masked[src_sel];

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= src_lvl;
  end

  assign src_rise = src_lvl & ~lvl_q;
endmodule

// File: rtl/cap_run_flag.sv
module cap_run_flag (
  input  logic clk,
  input  logic rst,
  input  logic trig_mode,
  input  logic src_rise,
  input  logic sw_set,
  input  logic sw_clr,
  output logic run_stat
);
  always_ff @(posedge clk) begin
    if (rst)                                run_stat <= 1'b0;
    else if (sw_clr)                        run_stat <= 1'b0;
    else if (sw_set || (trig_mode && src_rise)) run_stat <= 1'b1;
  end
endmodule

// File: rtl/cap_count_core.sv
module cap_count_core
  import cap_timebase_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tb_mode_e         mode,
  input  logic             tick,
  input  logic             src_lvl,
  input  logic             run_stat,
  input  logic             sw_clr,
  input  logic             casc_en,
  input  logic             casc_in,
  output logic [WIDTH-1:0] count,
  output logic             casc_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_nxt;
  logic             step;

  assign step = tick && (!casc_en || casc_in);

  always_comb begin
    cnt_nxt = count;
    unique case (mode)
      TB_TRIG: begin
        if (!run_stat || sw_clr) cnt_nxt = '0;
        else if (step)           cnt_nxt = count + 1'b1;
      end
      TB_SYNC: begin
        if (tick && src_lvl) cnt_nxt = '0;
        else if (step)       cnt_nxt = count + 1'b1;
      end
      default: begin
        if (step) cnt_nxt = count + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      casc_out <= 1'b0;
    end else begin
      count    <= cnt_nxt;
      casc_out <= (cnt_nxt == ALL_ONES);
    end
  end
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase
  import cap_timebase_pkg::*;
#(
  parameter int          WIDTH     = 16,
  parameter int          N_TICK    = 5,
  parameter int          CSEL_W    = 3,
  parameter int          SRC_W     = 5,
  parameter logic [31:0] RSVD_MASK = 32'h8001_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_TICK-1:0]     tick_src,
  input  logic [CSEL_W-1:0]     clk_sel,
  input  logic [SRC_W-1:0]      src_sel,
  input  logic [(1<<SRC_W)-1:0] src_vec,
  input  logic                  trig_mode,
  input  logic                  casc_en,
  input  logic                  casc_in,
  input  logic                  sw_set,
  input  logic                  sw_clr,
  output logic [WIDTH-1:0]      count,
  output logic                  casc_out,
  output logic                  run_stat
);
  logic     tick;
  logic     src_lvl;
  logic     src_rise;
  tb_mode_e mode;

  always_comb begin
    if (trig_mode)        mode = TB_TRIG;
    else if (src_sel != 0) mode = TB_SYNC;
    else                  mode = TB_FREE;
  end

  cap_tick_mux #(.N_TICK(N_TICK), .CSEL_W(CSEL_W)) u_tick (
    .tick_src(tick_src), .clk_sel(clk_sel), .tick(tick)
  );

  cap_src_pick #(.SRC_W(SRC_W), .RSVD_MASK(RSVD_MASK)) u_src (
    .clk(clk), .rst(rst), .src_sel(src_sel), .src_vec(src_vec),
    .src_lvl(src_lvl), .src_rise(src_rise)
  );

  cap_run_flag u_flag (
    .clk(clk), .rst(rst), .trig_mode(trig_mode), .src_rise(src_rise),
    .sw_set(sw_set), .sw_clr(sw_clr), .run_stat(run_stat)
  );

  cap_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .src_lvl(src_lvl),
    .run_stat(run_stat), .sw_clr(sw_clr), .casc_en(casc_en),
    .casc_in(casc_in), .count(count), .casc_out(casc_out)
  );
endmodule

// File: rtl/cap_timebase_chk.sv
module cap_timebase_chk #(
  parameter int WIDTH  = 16,
  parameter int CSEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CSEL_W-1:0] clk_sel,
  input logic              trig_mode,
  input logic              casc_en,
  input logic              casc_in,
  input logic              sw_clr,
  input logic [WIDTH-1:0]  count,
  input logic              casc_out,
  input logic              run_stat
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !casc_out && !run_stat));

  assert_carry_match_R5: assert property (@(posedge clk) disable iff (rst)
    casc_out == (count == {WIDTH{1'b1}}));

  assert_rsv_clock_idle_R4: assert property (@(posedge clk) disable iff (rst)
    ((clk_sel == 3'd5 || clk_sel == 3'd6) && !trig_mode) |=> $stable(count));

  assert_trig_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (trig_mode && !run_stat) |=> count == '0);

  assert_sw_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (trig_mode && sw_clr) |=> (count == '0 && !run_stat));

  assert_casc_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (casc_en && !casc_in) |=> (count == $past(count) || count == '0));
endmodule

bind cap_timebase cap_timebase_chk #(.WIDTH(WIDTH), .CSEL_W(CSEL_W)) u_chk (
  .clk(clk), .rst(rst), .clk_sel(clk_sel), .trig_mode(trig_mode),
  .casc_en(casc_en), .casc_in(casc_in), .sw_clr(sw_clr),
  .count(count), .casc_out(casc_out), .run_stat(run_stat)
);

// File: tb/cap_timebase_tb_top.sv
module cap_timebase_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   tick_src = '0;
  logic [2:0]   clk_sel = '0;
  logic [4:0]   src_sel = '0;
  logic [31:0]  src_vec = '0;
  logic         trig_mode = 1'b0;
  logic         sw_set = 1'b0;
  logic         sw_clr = 1'b0;
  logic [W-1:0] count, hi_count;
  logic         casc_out, hi_casc, run_stat, hi_stat;

  always #2.5 clk = ~clk;

  cap_timebase #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .tick_src(tick_src), .clk_sel(clk_sel),
    .src_sel(src_sel), .src_vec(src_vec), .trig_mode(trig_mode),
    .casc_en(1'b0), .casc_in(1'b0), .sw_set(sw_set), .sw_clr(sw_clr),
    .count(count), .casc_out(casc_out), .run_stat(run_stat)
  );

  cap_timebase #(.WIDTH(W)) dut_hi (
    .clk(clk), .rst(rst), .tick_src(5'b0), .clk_sel(3'd7),
    .src_sel(5'd0), .src_vec(32'b0), .trig_mode(1'b0),
    .casc_en(1'b1), .casc_in(casc_out), .sw_set(1'b0), .sw_clr(1'b0),
    .count(hi_count), .casc_out(hi_casc), .run_stat(hi_stat)
  );

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_v(input int kind, input int exp, input string tag);
    exp_t e;
    e.kind = kind; e.exp = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_lo(input int c, input int st, input string tag);
    expect_v(0, c, tag);
    expect_v(2, st, tag);
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      int   act;
      e = q.pop_front();
      case (e.kind)
        0:       act = int'(count);
        1:       act = int'(casc_out);
        2:       act = int'(run_stat);
        default: act = int'(hi_count);
      endcase
      n_chk++;
      if (act != e.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", e.tag, e.kind, act, e.exp);
      end
    end
  end

  initial begin
    cyc(2);
    expect_lo(0, 0, "R1"); expect_v(1, 0, "R1"); expect_v(3, 0, "R1");
    rst = 1'b0; clk_sel = 3'd7;
    cyc(10); expect_lo(10, 0, "R2");
    clk_sel = 3'd5; cyc(5); expect_v(0, 10, "R4");
    clk_sel = 3'd6; cyc(3); expect_v(0, 10, "R4");
    tick_src = 5'b00100; clk_sel = 3'd2; cyc(4); expect_v(0, 14, "R3");
    clk_sel = 3'd0; cyc(4); expect_v(0, 14, "R3");
    clk_sel = 3'd7; cyc(241);
    expect_v(0, 255, "R5"); expect_v(1, 1, "R5"); expect_v(3, 0, "R11");
    cyc(1);
    expect_v(0, 0, "R5"); expect_v(1, 0, "R5"); expect_v(3, 1, "R11");
    // sync mode
    cyc(5); expect_v(0, 5, "R6");
    src_sel = 5'd3; src_vec[3] = 1'b1; cyc(1); expect_v(0, 0, "R6");
    cyc(3); expect_v(0, 0, "R6");
    src_vec[3] = 1'b0; cyc(2); expect_v(0, 2, "R6");
    clk_sel = 3'd2; tick_src = 5'b0; src_vec[3] = 1'b1; cyc(3); expect_v(0, 2, "R6");
    tick_src = 5'b00100; cyc(1); expect_v(0, 0, "R6");
    src_vec[3] = 1'b0; clk_sel = 3'd7; cyc(1); expect_v(0, 1, "R6");
    src_sel = 5'd16; src_vec[16] = 1'b1; cyc(4); expect_v(0, 5, "R7");
    src_sel = 5'd0; src_vec[0] = 1'b1; cyc(3); expect_v(0, 8, "R7");
    src_vec = '0;
    // trigger mode
    trig_mode = 1'b1; src_sel = 5'd3; cyc(1); expect_lo(0, 0, "R8");
    cyc(5); expect_lo(0, 0, "R8");
    src_vec[3] = 1'b1; cyc(1); expect_lo(0, 1, "R8");
    cyc(3); expect_lo(3, 1, "R8");
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0; expect_lo(0, 0, "R9");
    cyc(4); expect_lo(0, 0, "R8");
    src_vec[3] = 1'b0; cyc(1); src_vec[3] = 1'b1; cyc(1); expect_lo(0, 1, "R8");
    cyc(2); expect_lo(2, 1, "R8");
    src_vec[3] = 1'b0;
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0; expect_lo(0, 0, "R9");
    src_sel = 5'd0; cyc(3); expect_lo(0, 0, "R9");
    sw_set = 1'b1; cyc(1); sw_set = 1'b0; expect_lo(0, 1, "R9");
    cyc(5); expect_lo(5, 1, "R9");
    // status has no effect outside trigger mode
    trig_mode = 1'b0; sw_clr = 1'b1; cyc(1); sw_clr = 1'b0; expect_lo(6, 0, "R10");
    cyc(2); expect_lo(8, 0, "R10");
    sw_set = 1'b1; cyc(1); sw_set = 1'b0; expect_lo(9, 1, "R10");
    cyc(1); expect_v(0, 10, "R10");
    // cascade carry
    cyc(245); expect_v(0, 255, "R11"); expect_v(3, 1, "R11");
    cyc(1); expect_v(0, 0, "R11"); expect_v(3, 2, "R11");
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule